// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Line Refill

This block sits between the instruction-fetch port of a processor and a slower backing memory. It is read-only. The fetch side reads 32-bit words through a memory-mapped slave port and is stalled with a waitrequest signal. Behind the cache, a bursting memory-mapped master port fetches a whole line of eight words at a time. The slave and master address spaces are the same, so word address N on the fetch side is word address N in the backing memory, with no offset added.

The storage is direct-mapped: eight lines of eight words each. A word address splits into a tag (upper bits), a 3-bit line index (bits 5:3) and a 3-bit word offset (bits 2:0). Each line has one valid flag. On a hit the requested word is presented after a fixed delay. On a miss the cache issues a single burst read for the line-aligned address, writes each returned beat into the line, and then serves the word from the refilled line. The cache does not support writes. It does not watch for other agents changing the backing memory, so contents are assumed constant while it runs.

Top module: `icache_top`

## Requirements
- R1: While reset is held and after it is released, s_waitrequest is 1 and m_read is 0. Reset clears every valid flag, so the first read of any line after reset causes a burst.
- R2: Once s_read is asserted, s_waitrequest stays 1 until the data cycle. It is 0 for exactly one cycle, and in that cycle s_readdata holds the requested word.
- R3: On a hit, s_read is asserted in cycle 0 and s_waitrequest is 1 in cycles 0 and 1. s_waitrequest is 0 with valid data in cycle 2, and no burst is issued.
- R4: On a miss, m_read is asserted with m_burstcount = 8 and m_address equal to the requested word address with bits 2:0 cleared. m_read and m_address are held until a cycle in which m_waitrequest is 0.
- R5: After a refill, the word returned is the backing memory's word at the requested address. The beat order is line base plus 0 to 7.
- R6: The refill accepts one beat per cycle in which m_readdatavalid is 1. It tolerates idle cycles between beats and m_waitrequest stall cycles before the burst is accepted.
- R7: After a refill, a read of any other word in the same line is a hit.
- R8: A read whose index matches a cached line but whose tag differs misses and replaces that line. A later read of the replaced line misses again.
- R9: If s_read is held high across a completion, it counts as a new request and completes again three cycles later.
- R10: A backing-memory change after a line is cached is not seen. A hit returns the word stored at refill time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_address | input | ADDR_W (12) | Fetch word address |
| s_read | input | 1 | Fetch read strobe |
| s_readdata | output | 32 | Fetched word, valid when s_waitrequest is 0 |
| s_waitrequest | output | 1 | Stall to the fetch side |
| m_address | output | ADDR_W (12) | Line-aligned burst word address |
| m_read | output | 1 | Burst read request |
| m_burstcount | output | 4 | Beats per burst, always 8 |
| m_waitrequest | input | 1 | Backing memory not ready to accept the request |
| m_readdata | input | 32 | Burst beat data |
| m_readdatavalid | input | 1 | Burst beat valid |

## Verification
The case hardest to reach from the ports is a refill whose beats arrive with gaps after the request itself has been stalled. A second hard case is a conflict eviction followed by a re-read of the evicted line. The bench memory model can stretch its request stall from zero to three cycles and insert an idle cycle between every beat. A vector table then orders reads so that two tags share index 0 and alternate. Coherence is reached by changing the memory's contents after a line is cached and reading back a hit.

// File: rtl/icache_pkg.sv
// Package: shared controller state type for the instruction cache.
// Assumes: nothing beyond the importing modules.
package icache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_REQ,
        ST_FILL,
        ST_DONE
    } cache_st_e;
endpackage

// File: rtl/icache_tags.sv
// Tag and valid storage, one entry per line.
// Assumes: a single write port used only at the end of a refill; reads are combinational.
module icache_tags #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid flags: cleared by reset, set when a line refill completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag storage: written together with the valid flag.
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_tag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tag_q[g] <= '0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    tag_q[g] <= wr_tag;
                end
            end
        end
    endgenerate

    // Lookup port.
    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/icache_data.sv
// Line data storage, addressed by index and word offset.
// Assumes: one write per cycle during a refill; reads are combinational.
module icache_data #(
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] mem_q [WORDS];

    // Beat write from the burst return path.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_off}] <= wr_data;
        end
    end

    // Word read for a hit.
    assign rd_data = mem_q[{rd_idx, rd_off}];
endmodule

// File: rtl/icache_ctrl.sv
// Cache controller: accepts one fetch at a time, looks it up, refills on a miss.
// Assumes: the requester holds s_address while s_waitrequest is 1, and the
// memory returns exactly as many beats as it was asked for.
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 3,
    parameter int DATA_W = 32,
    parameter int BC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_address,
    input  logic              s_read,
    output logic              s_waitrequest,
    output logic [DATA_W-1:0] s_readdata,
    output logic [ADDR_W-1:0] m_address,
    output logic              m_read,
    output logic [BC_W-1:0]   m_burstcount,
    input  logic              m_waitrequest,
    input  logic              m_readdatavalid,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [OFF_W-1:0]  lk_off,
    input  logic              lk_valid,
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    output logic              tag_we,
    output logic              data_we,
    output logic [OFF_W-1:0]  beat_off
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_WORDS = 1 << OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

    cache_st_e         state_q;
    logic [ADDR_W-1:0] req_q;
    logic [OFF_W-1:0]  beat_q;
    logic [DATA_W-1:0] out_q;
    logic [TAG_W-1:0]  req_tag;
    logic              hit;

    assign req_tag = req_q[ADDR_W-1 -: TAG_W];
    assign lk_idx  = req_q[OFF_W +: IDX_W];
    assign lk_off  = req_q[OFF_W-1:0];
    assign hit     = lk_valid && (lk_tag == req_tag);

    // Request sequencing: capture, lookup, burst request, beat collection, reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            beat_q  <= '0;
            out_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (s_read) begin
                        req_q   <= s_address;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        out_q   <= lk_data;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (!m_waitrequest) begin
                        beat_q  <= '0;
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (m_readdatavalid) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) begin
                            state_q <= ST_LOOKUP;
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port and storage control decoded from the state.
    always_comb begin
        s_waitrequest = (state_q != ST_DONE);
        s_readdata    = out_q;
        m_read        = (state_q == ST_REQ);
        m_address     = {req_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        m_burstcount  = BC_W'(LINE_WORDS);
        data_we       = (state_q == ST_FILL) && m_readdatavalid;
        tag_we        = data_we && (beat_q == LAST_BEAT);
        beat_off      = beat_q;
    end
endmodule

// File: rtl/icache_top.sv
// Read-only direct-mapped instruction cache with whole-line burst refill.
// Assumes: 32-bit words, word addressing on both ports, no writes from the fetch side.
module icache_top #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 3,
    parameter int DATA_W = 32,
    parameter int BC_W   = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_address,
    input  logic              s_read,
    output logic [DATA_W-1:0] s_readdata,
    output logic              s_waitrequest,
    output logic [ADDR_W-1:0] m_address,
    output logic              m_read,
    output logic [BC_W-1:0]   m_burstcount,
    input  logic              m_waitrequest,
    input  logic [DATA_W-1:0] m_readdata,
    input  logic              m_readdatavalid
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]  lk_idx;
    logic [OFF_W-1:0]  lk_off;
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              tag_we;
    logic              data_we;
    logic [OFF_W-1:0]  beat_off;

    icache_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .BC_W(BC_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .s_address(s_address), .s_read(s_read),
        .s_waitrequest(s_waitrequest), .s_readdata(s_readdata),
        .m_address(m_address), .m_read(m_read), .m_burstcount(m_burstcount),
        .m_waitrequest(m_waitrequest), .m_readdatavalid(m_readdatavalid),
        .lk_idx(lk_idx), .lk_off(lk_off), .lk_valid(lk_valid), .lk_tag(lk_tag),
        .lk_data(lk_data), .tag_we(tag_we), .data_we(data_we), .beat_off(beat_off)
    );

    icache_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_valid(lk_valid), .rd_tag(lk_tag),
        .wr_en(tag_we), .wr_idx(lk_idx), .wr_tag(m_address[ADDR_W-1 -: TAG_W])
    );

    icache_data #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .wr_en(data_we), .wr_idx(lk_idx), .wr_off(beat_off), .wr_data(m_readdata),
        .rd_idx(lk_idx), .rd_off(lk_off), .rd_data(lk_data)
    );
endmodule

// File: rtl/icache_checker.sv
// Protocol checker for icache_top, attached with bind.
// Assumes: the requester holds s_address stable while stalled.
module icache_checker #(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 3,
    parameter int BC_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] s_address,
    input logic              s_read,
    input logic              s_waitrequest,
    input logic [ADDR_W-1:0] m_address,
    input logic              m_read,
    input logic [BC_W-1:0]   m_burstcount,
    input logic              m_waitrequest
);
    localparam int LINE_WORDS = 1 << OFF_W;

    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_read |-> m_burstcount == BC_W'(LINE_WORDS));

    p_line_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_read |-> m_address[OFF_W-1:0] == '0);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read && m_waitrequest) |=> (m_read && $stable(m_address)));

    p_single_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_waitrequest |=> s_waitrequest);

    p_line_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_read) |-> m_address[ADDR_W-1:OFF_W] == $past(s_address[ADDR_W-1:OFF_W]));

    p_no_burst_on_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_waitrequest |-> !m_read);
endmodule

bind icache_top icache_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BC_W(BC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_address(s_address), .s_read(s_read),
    .s_waitrequest(s_waitrequest), .m_address(m_address), .m_read(m_read),
    .m_burstcount(m_burstcount), .m_waitrequest(m_waitrequest)
);

// File: tb/tb_icache_top.sv
module tb_icache_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] s_address = '0;
    logic        s_read = 1'b0;
    logic [31:0] s_readdata;
    logic        s_waitrequest;
    logic [11:0] m_address;
    logic        m_read;
    logic [3:0]  m_burstcount;
    logic        m_waitrequest;
    logic [31:0] m_readdata;
    logic        m_readdatavalid;

    always #4 clk = ~clk;

    icache_top dut (.*);

    int tests = 0;
    int fails = 0;

    // Backing memory model
    logic [31:0] mem_xor = '0;
    bit          gaps_on = 0;
    int          req_delay = 0;
    int          dly_cnt = 0;
    bit          pend = 0;
    bit          tog = 0;
    logic [11:0] base_q = '0;
    int          beat = 0;
    int          burst_cnt = 0;
    logic [11:0] last_base = '0;
    logic [3:0]  last_bc = '0;
    logic        rdv_q = 1'b0;
    logic [31:0] rdata_q = '0;

    function automatic logic [31:0] mem_word(input logic [11:0] a);
        return {4'hA, a, 4'h5, ~a} ^ mem_xor;
    endfunction

    assign m_waitrequest   = pend || (dly_cnt < req_delay);
    assign m_readdata      = rdata_q;
    assign m_readdatavalid = rdv_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 0; dly_cnt <= 0; rdv_q <= 1'b0; beat <= 0;
        end else if (pend) begin
            tog <= ~tog;
            if (gaps_on && tog) begin
                rdv_q <= 1'b0;
            end else begin
                rdv_q   <= 1'b1;
                rdata_q <= mem_word(base_q + 12'(beat));
                beat    <= beat + 1;
                if (beat == 7) pend <= 0;
            end
        end else begin
            rdv_q <= 1'b0;
            if (m_read) begin
                if (dly_cnt < req_delay) dly_cnt <= dly_cnt + 1;
                else begin
                    pend <= 1; tog <= 1'b0; beat <= 0; dly_cnt <= 0;
                    base_q <= m_address; last_base <= m_address; last_bc <= m_burstcount;
                    burst_cnt <= burst_cnt + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d, output int cyc);
        bit done = 0;
        @(negedge clk);
        s_address = a; s_read = 1'b1; cyc = 0; d = '0;
        while (!done) begin
            if (!s_waitrequest) begin
                d = s_readdata; done = 1;
            end else begin
                cyc++;
                if (cyc > 300) begin
                    check(0, "R2 timeout", 32'(cyc), 32'd300); done = 1;
                end else @(negedge clk);
            end
        end
        @(negedge clk);
        s_read = 1'b0;
        check(s_waitrequest == 1'b1, "R2 one-cycle reply", 32'(s_waitrequest), 32'd1);
    endtask

    typedef struct packed {
        logic [11:0] addr;
        logic        hit;
        logic        gaps;
        logic [1:0]  dly;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{12'h000, 1'b0, 1'b0, 2'd0},   // R1 first access misses
        '{12'h005, 1'b1, 1'b0, 2'd0},   // R7 same line hits
        '{12'h00F, 1'b0, 1'b1, 2'd2},   // R6 gaps and stall
        '{12'h009, 1'b1, 1'b0, 2'd0},   // R7
        '{12'h043, 1'b0, 1'b0, 2'd1},   // R8 conflict on index 0
        '{12'h002, 1'b0, 1'b1, 2'd0},   // R8 evicted line misses
        '{12'h047, 1'b0, 1'b0, 2'd3},   // R8 evicted again
        '{12'hFFF, 1'b0, 1'b1, 2'd1},   // R5 top of space
        '{12'hFF8, 1'b1, 1'b0, 2'd0},   // R7
        '{12'h00A, 1'b1, 1'b0, 2'd0}    // R7 line 1 still present
    };

    int cycles = 0;
    bit wd_fired = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !wd_fired) begin
            wd_fired = 1;
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected <100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int cyc;
        int b0;
        int lows;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(s_waitrequest == 1'b1, "R1 wr in reset", 32'(s_waitrequest), 32'd1);
        check(m_read == 1'b0, "R1 m_read in reset", 32'(m_read), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(s_waitrequest == 1'b1 && m_read == 1'b0, "R1 idle after reset",
              {30'd0, s_waitrequest, m_read}, 32'd2);

        // Vector table
        for (int i = 0; i < 10; i++) begin
            gaps_on = VECS[i].gaps;
            req_delay = int'(VECS[i].dly);
            b0 = burst_cnt;
            do_read(VECS[i].addr, d, cyc);
            check(d == mem_word(VECS[i].addr), "R5 data", d, mem_word(VECS[i].addr));
            if (VECS[i].hit) begin
                check(cyc == 2, "R3 hit latency", 32'(cyc), 32'd2);
                check(burst_cnt == b0, "R7 no burst on hit", 32'(burst_cnt - b0), 32'd0);
            end else begin
                check(burst_cnt == b0 + 1, "R4 one burst per miss", 32'(burst_cnt - b0), 32'd1);
                check(last_base == {VECS[i].addr[11:3], 3'b000}, "R4 line address",
                      32'(last_base), 32'({VECS[i].addr[11:3], 3'b000}));
                check(last_bc == 4'd8, "R4 burstcount", 32'(last_bc), 32'd8);
                check(cyc > 2, "R6 miss stalls", 32'(cyc), 32'd3);
            end
        end
        gaps_on = 0; req_delay = 0;

        // R9: read held across completion on a cached word
        @(negedge clk);
        s_address = 12'hFFA; s_read = 1'b1; lows = 0;
        for (int k = 0; k < 6; k++) begin
            if (!s_waitrequest) begin
                lows++;
                check(s_readdata == mem_word(12'hFFA), "R9 data", s_readdata, mem_word(12'hFFA));
            end
            @(negedge clk);
        end
        s_read = 1'b0;
        check(lows == 2, "R9 two completions", 32'(lows), 32'd2);

        // R10: memory changes are not seen on a hit
        mem_xor = 32'h0000_FFFF;
        b0 = burst_cnt;
        do_read(12'h009, d, cyc);
        check(d == ({4'hA, 12'h009, 4'h5, ~12'h009}), "R10 stale hit",
              d, {4'hA, 12'h009, 4'h5, ~12'h009});
        check(burst_cnt == b0, "R10 no refill", 32'(burst_cnt - b0), 32'd0);
        do_read(12'h0C9, d, cyc);
        check(d == mem_word(12'h0C9), "R8 replace index 1", d, mem_word(12'h0C9));

        // R1: reset in mid-run clears valid flags
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(s_waitrequest == 1'b1 && m_read == 1'b0, "R1 after second reset",
              {30'd0, s_waitrequest, m_read}, 32'd2);
        b0 = burst_cnt;
        do_read(12'hFF8, d, cyc);
        check(burst_cnt == b0 + 1, "R1 miss after reset", 32'(burst_cnt - b0), 32'd1);
        check(d == mem_word(12'hFF8), "R5 refill new contents", d, mem_word(12'hFF8));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule